// File: doc/BRIEF.md
# Masked Vector Unpack-Low Interleave Unit

This unit forms a destination vector of up to 512 bits out of two source vectors built from 64-bit elements. Each 128-bit lane of the result is filled from the lower qword of the same lane in both sources: the first source supplies the lower half of the lane and the second source supplies the upper half. The element values are copied bit for bit. No floating-point interpretation is applied and no exception can be raised.

The unit serves three operating modes. The legacy mode is fixed at 128 bits and passes the old destination through above the low lane. The plain mode is unmasked, has a selectable length and clears every bit above that length. The masked mode has a selectable length and uses a per-element write mask, which either merges the old destination value or writes zero. In masked mode only, the second operand can be broadcast from one scalar. The unit captures a result when its input strobe is high, and that result appears one clock later along with a valid flag.

Top module: `vec_unpack_lo`

## Requirements
- R1: For every active 128-bit lane L, result[128L+63:128L] equals src_a[128L+63:128L] and result[128L+127:128L+64] equals src_b[128L+63:128L]. The upper qword of each lane in either source has no effect on the result.
- R2: vlen_sel selects the active length. 0 gives 128 bits (elements 0-1), 1 gives 256 bits (elements 0-3), and 2 or 3 gives 512 bits (elements 0-7).
- R3: In masked mode (mode_sel 2 or 3) with bcast_en=1, every 64-bit element of src_b is replaced by src_b[63:0] before the interleave. In modes 0 and 1, bcast_en has no effect.
- R4: In masked mode with mask_en=1, active element j takes the interleaved value only when wmask[j]=1. When mask_en=0 the mask behaves as all ones. In modes 0 and 1, wmask, mask_en and zero_en have no effect.
- R5: An active element whose effective mask bit is 0 becomes zero when zero_en=1 and keeps old_dst's element when zero_en=0.
- R6: In plain and masked modes, every result bit above the active length is zero.
- R7: In legacy mode (mode_sel 0), vlen_sel is ignored and the length is 128 bits. Bits 511:128 of the result equal old_dst[511:128], and the low lane follows R1.
- R8: wmask bits at or above the active element count have no effect.
- R9: result and out_valid update one cycle after in_valid=1. In a cycle after in_valid=0, out_valid is 0 and result holds its previous value.
- R10: A synchronous active-low reset clears result and out_valid to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Capture strobe for the operands |
| vlen_sel | input | 2 | Vector length select |
| mode_sel | input | 2 | 0 legacy, 1 plain, 2/3 masked |
| wmask | input | 8 | Per-element write mask |
| mask_en | input | 1 | Apply wmask in masked mode |
| zero_en | input | 1 | 1 zeroing, 0 merging for masked-off elements |
| bcast_en | input | 1 | Broadcast src_b[63:0] in masked mode |
| src_a | input | 512 | First source vector |
| src_b | input | 512 | Second source vector |
| old_dst | input | 512 | Previous destination value |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| result | output | 512 | Registered destination vector |

## Verification
Every result and out_valid is due at the first rising edge after the edge that sampled in_valid=1. The bench drives its inputs on falling edges, lets one rising edge pass, drops the strobe and then compares both outputs at the next falling edge. The expected values are computed from the requirements at that point. The hold checks look one further cycle ahead with the strobe low and the operands changed, which confirms that the earlier result is still in place.

// File: rtl/vul_pkg.sv
// Shared encodings for the unpack-low interleave unit.
// Assumes 2-bit select fields for vector length and operating mode.
package vul_pkg;
    typedef enum logic [1:0] {
        VL_128  = 2'd0,
        VL_256  = 2'd1,
        VL_512  = 2'd2,
        VL_512X = 2'd3
    } vlen_e;

    typedef enum logic [1:0] {
        MD_LEGACY  = 2'd0,
        MD_PLAIN   = 2'd1,
        MD_MASKED  = 2'd2,
        MD_MASKED2 = 2'd3
    } mode_e;

    // Number of active elements for a given length select, limited to num_elem.
    function automatic int unsigned active_count(input logic [1:0] vl, input int unsigned num_elem);
        int unsigned n;
        case (vl)
            VL_128:  n = 2;
            VL_256:  n = 4;
            default: n = 8;
        endcase
        if (n > num_elem) n = num_elem;
        return n;
    endfunction
endpackage

// File: rtl/vul_src_bcast.sv
// Operand conditioner for the second source. When do_bcast is high it
// copies element 0 into every element position. Assumes the caller has
// already qualified do_bcast with the operating mode.
module vul_src_bcast #(
    parameter int ELEM_W   = 64,
    parameter int NUM_ELEM = 8,
    localparam int VEC_W   = ELEM_W * NUM_ELEM
) (
    input  logic             do_bcast,
    input  logic [VEC_W-1:0] src_in,
    output logic [VEC_W-1:0] src_out
);
    for (genvar e = 0; e < NUM_ELEM; e++) begin : g_elem
        // Pick the element's own value or the replicated scalar.
        assign src_out[e*ELEM_W +: ELEM_W] = do_bcast ? src_in[0 +: ELEM_W]
                                                      : src_in[e*ELEM_W +: ELEM_W];
    end
endmodule

// File: rtl/vul_lane_mix.sv
// Lane interleaver. In each two-element lane, element 0 of the output is
// the low element of a and element 1 is the low element of b. The high
// element of each lane in either source is not used. Assumes NUM_ELEM is even.
module vul_lane_mix #(
    parameter int ELEM_W   = 64,
    parameter int NUM_ELEM = 8,
    localparam int VEC_W     = ELEM_W * NUM_ELEM,
    localparam int NUM_LANES = NUM_ELEM / 2
) (
    input  logic [VEC_W-1:0] vec_a,
    input  logic [VEC_W-1:0] vec_b,
    output logic [VEC_W-1:0] mixed
);
    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        // Low half of the lane comes from a, high half from b, both from their low element.
        assign mixed[(2*l)*ELEM_W   +: ELEM_W] = vec_a[(2*l)*ELEM_W +: ELEM_W];
        assign mixed[(2*l+1)*ELEM_W +: ELEM_W] = vec_b[(2*l)*ELEM_W +: ELEM_W];
    end
endmodule

// File: rtl/vul_elem_sel.sv
// Per-element writer. It resolves the active length, the effective mask
// and the fill value used for masked-off and inactive elements, and then
// produces the next destination value. Assumes NUM_ELEM <= 8 mask bits.
module vul_elem_sel
    import vul_pkg::*;
#(
    parameter int ELEM_W   = 64,
    parameter int NUM_ELEM = 8,
    localparam int VEC_W   = ELEM_W * NUM_ELEM
) (
    input  logic [1:0]          vlen_sel,
    input  logic [1:0]          mode_sel,
    input  logic [NUM_ELEM-1:0] wmask,
    input  logic                mask_en,
    input  logic                zero_en,
    input  logic [VEC_W-1:0]    mixed,
    input  logic [VEC_W-1:0]    old_dst,
    output logic [VEC_W-1:0]    next_dst
);
    logic                legacy;
    logic                masked;
    logic [NUM_ELEM-1:0] active;
    logic [NUM_ELEM-1:0] eff_mask;

    // Mode decode: the masked mode occupies both upper codes.
    always_comb begin
        legacy = (mode_e'(mode_sel) == MD_LEGACY);
        masked = mode_sel[1];
    end

    // Active-element vector: legacy is fixed at 128 bits.
    always_comb begin
        int unsigned n;
        n = legacy ? 2 : active_count(vlen_sel, NUM_ELEM);
        for (int j = 0; j < NUM_ELEM; j++) active[j] = (j < n);
    end

    // Effective mask: all ones unless masked mode with the mask enabled.
    always_comb begin
        eff_mask = (masked && mask_en) ? wmask : '1;
    end

    for (genvar e = 0; e < NUM_ELEM; e++) begin : g_elem
        logic [ELEM_W-1:0] old_e;
        logic [ELEM_W-1:0] fill_e;
        assign old_e = old_dst[e*ELEM_W +: ELEM_W];
        // Fill value: legacy passes the old upper part, masking merges or zeroes.
        always_comb begin
            if (!active[e])
                fill_e = legacy ? old_e : '0;
            else
                fill_e = zero_en ? '0 : old_e;
        end
        // Element result: interleaved value when active and enabled.
        assign next_dst[e*ELEM_W +: ELEM_W] =
            (active[e] && eff_mask[e]) ? mixed[e*ELEM_W +: ELEM_W] : fill_e;
    end
endmodule

// File: rtl/vec_unpack_lo.sv
// Top of the unpack-low interleave unit. It conditions the second
// operand, interleaves the lanes, applies the write mask and the length,
// and registers the result on in_valid. The output is registered, with a
// latency of one cycle. Assumes the operands are stable during the strobe.
module vec_unpack_lo
    import vul_pkg::*;
#(
    parameter int ELEM_W   = 64,
    parameter int NUM_ELEM = 8,
    localparam int VEC_W   = ELEM_W * NUM_ELEM,
    localparam int LANE_W  = 2 * ELEM_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [1:0]          vlen_sel,
    input  logic [1:0]          mode_sel,
    input  logic [NUM_ELEM-1:0] wmask,
    input  logic                mask_en,
    input  logic                zero_en,
    input  logic                bcast_en,
    input  logic [VEC_W-1:0]    src_a,
    input  logic [VEC_W-1:0]    src_b,
    input  logic [VEC_W-1:0]    old_dst,
    output logic                out_valid,
    output logic [VEC_W-1:0]    result
);
    logic             do_bcast;
    logic [VEC_W-1:0] b_cond;
    logic [VEC_W-1:0] mixed;
    logic [VEC_W-1:0] next_dst;

    // Broadcast applies only in masked mode.
    assign do_bcast = bcast_en && mode_sel[1];

    vul_src_bcast #(.ELEM_W(ELEM_W), .NUM_ELEM(NUM_ELEM)) bcast_i (
        .do_bcast (do_bcast),
        .src_in   (src_b),
        .src_out  (b_cond)
    );

    vul_lane_mix #(.ELEM_W(ELEM_W), .NUM_ELEM(NUM_ELEM)) mix_i (
        .vec_a (src_a),
        .vec_b (b_cond),
        .mixed (mixed)
    );

    vul_elem_sel #(.ELEM_W(ELEM_W), .NUM_ELEM(NUM_ELEM)) sel_i (
        .vlen_sel (vlen_sel),
        .mode_sel (mode_sel),
        .wmask    (wmask),
        .mask_en  (mask_en),
        .zero_en  (zero_en),
        .mixed    (mixed),
        .old_dst  (old_dst),
        .next_dst (next_dst)
    );

    // Output register: captures on the strobe and clears on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) result <= next_dst;
        end
    end

    // R9: a strobe produces a valid result one cycle later.
    a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R9: without a strobe the result holds and valid drops.
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result)));

    // R1: with the element enabled, element 0 comes from src_a.
    a_r1_elem0: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (!mode_sel[1] || !mask_en || wmask[0]))
        |=> result[ELEM_W-1:0] == $past(src_a[ELEM_W-1:0]));

    // R5: zeroing clears a masked-off element 0.
    a_r5_zero_elem0: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode_sel[1] && mask_en && zero_en && !wmask[0])
        |=> result[ELEM_W-1:0] == '0);

    // R6: non-legacy 128-bit results are zero above the low lane.
    a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode_sel != 2'd0 && vlen_sel == 2'd0)
        |=> result[VEC_W-1:LANE_W] == '0);

    // R7: legacy mode passes old_dst above the low lane.
    a_r7_legacy_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode_sel == 2'd0)
        |=> result[VEC_W-1:LANE_W] == $past(old_dst[VEC_W-1:LANE_W]));
endmodule

// File: tb/vec_unpack_lo_tb_top.sv
module vec_unpack_lo_tb_top;
    localparam int EW = 64;
    localparam int NE = 8;
    localparam int VW = EW * NE;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [1:0]    vlen_sel = '0;
    logic [1:0]    mode_sel = '0;
    logic [NE-1:0] wmask = '0;
    logic          mask_en = 1'b0;
    logic          zero_en = 1'b0;
    logic          bcast_en = 1'b0;
    logic [VW-1:0] src_a = '0;
    logic [VW-1:0] src_b = '0;
    logic [VW-1:0] old_dst = '0;
    logic          out_valid;
    logic [VW-1:0] result;

    int n_checks = 0;
    int n_bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    vec_unpack_lo dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .vlen_sel(vlen_sel),
        .mode_sel(mode_sel), .wmask(wmask), .mask_en(mask_en), .zero_en(zero_en),
        .bcast_en(bcast_en), .src_a(src_a), .src_b(src_b), .old_dst(old_dst),
        .out_valid(out_valid), .result(result)
    );

    // Distinct per-element pattern built from a seed.
    function automatic logic [VW-1:0] pat(input logic [15:0] seed);
        logic [VW-1:0] v;
        for (int j = 0; j < NE; j++)
            v[j*EW +: EW] = {seed, 16'hC0DE, 16'(j + 1), seed ^ 16'hFFFF};
        return v;
    endfunction

    // Expected destination from the requirements.
    function automatic logic [VW-1:0] model();
        logic [VW-1:0] r;
        logic [VW-1:0] bb;
        logic [EW-1:0] mix;
        bit legacy, masked, m;
        int n;
        legacy = (mode_sel == 2'd0);
        masked = mode_sel[1];
        n = legacy ? 2 : (vlen_sel == 2'd0 ? 2 : (vlen_sel == 2'd1 ? 4 : 8));
        bb = src_b;
        if (masked && bcast_en)
            for (int j = 0; j < NE; j++) bb[j*EW +: EW] = src_b[EW-1:0];
        for (int j = 0; j < NE; j++) begin
            if (j >= n) begin
                r[j*EW +: EW] = legacy ? old_dst[j*EW +: EW] : '0;
            end else begin
                mix = (j % 2 == 0) ? src_a[j*EW +: EW] : bb[(j-1)*EW +: EW];
                m = (masked && mask_en) ? wmask[j] : 1'b1;
                r[j*EW +: EW] = m ? mix : (zero_en ? '0 : old_dst[j*EW +: EW]);
            end
        end
        return r;
    endfunction

    task automatic check_vec(input string req, input logic [VW-1:0] exp_v, input logic exp_vld);
        n_checks++;
        if (result !== exp_v || out_valid !== exp_vld) begin
            n_bad++;
            $display("FAIL %s: result=%h valid=%b expected=%h valid=%b",
                     req, result, out_valid, exp_v, exp_vld);
        end
    endtask

    // Drive one operation, let it register, then compare.
    task automatic run_op(input string req, input logic [1:0] vl, input logic [1:0] md,
                          input logic [NE-1:0] wm, input logic me, input logic ze,
                          input logic bc, input logic [15:0] seed);
        logic [VW-1:0] exp_v;
        @(negedge clk);
        vlen_sel = vl; mode_sel = md; wmask = wm; mask_en = me; zero_en = ze;
        bcast_en = bc; src_a = pat(seed); src_b = pat(seed + 16'h1111);
        old_dst = pat(seed + 16'h2222);
        in_valid = 1'b1;
        exp_v = model();
        @(negedge clk);
        in_valid = 1'b0;
        check_vec(req, exp_v, 1'b1);
    endtask

    task automatic t_reset();
        // R10: reset clears the outputs.
        check_vec("R10 reset state", '0, 1'b0);
    endtask

    task automatic t_lengths();
        // R1 R2 R6: plain mode at each length, including code 3.
        run_op("R1 R2 R6 plain 128", 2'd0, 2'd1, 8'h00, 1'b1, 1'b1, 1'b1, 16'h1000);
        run_op("R1 R2 R6 plain 256", 2'd1, 2'd1, 8'h00, 1'b1, 1'b1, 1'b1, 16'h2000);
        run_op("R1 R2 plain 512",    2'd2, 2'd1, 8'h00, 1'b0, 1'b0, 1'b0, 16'h3000);
        run_op("R2 plain code3 512", 2'd3, 2'd1, 8'h00, 1'b0, 1'b0, 1'b0, 16'h3100);
        run_op("R1 R6 masked 256 unmasked", 2'd1, 2'd2, 8'h00, 1'b0, 1'b1, 1'b0, 16'h3200);
    endtask

    task automatic t_legacy();
        // R7: legacy ignores vlen, mask and broadcast and keeps old upper bits.
        run_op("R7 legacy vlen512", 2'd2, 2'd0, 8'h00, 1'b1, 1'b1, 1'b1, 16'h4000);
        run_op("R7 legacy vlen128", 2'd0, 2'd0, 8'h55, 1'b1, 1'b0, 1'b0, 16'h4100);
    endtask

    task automatic t_bcast();
        // R3: masked-mode broadcast, and no effect in plain mode.
        run_op("R3 bcast masked 512", 2'd2, 2'd2, 8'hFF, 1'b1, 1'b0, 1'b1, 16'h5000);
        run_op("R3 bcast mode3 256",  2'd1, 2'd3, 8'h0F, 1'b0, 1'b0, 1'b1, 16'h5100);
        run_op("R3 bcast ignored plain", 2'd2, 2'd1, 8'hFF, 1'b0, 1'b0, 1'b1, 16'h5200);
    endtask

    task automatic t_mask();
        // R4 R5: merging and zeroing under a partial mask.
        run_op("R4 R5 merge 512", 2'd2, 2'd2, 8'hA5, 1'b1, 1'b0, 1'b0, 16'h6000);
        run_op("R4 R5 zero 512",  2'd2, 2'd2, 8'h5A, 1'b1, 1'b1, 1'b0, 16'h6100);
        run_op("R4 R5 zero bcast 256", 2'd1, 2'd3, 8'h06, 1'b1, 1'b1, 1'b1, 16'h6200);
        run_op("R4 mask ignored plain", 2'd2, 2'd1, 8'h00, 1'b1, 1'b1, 1'b0, 16'h6300);
    endtask

    task automatic t_high_mask();
        // R8: mask bits beyond the active length do nothing.
        run_op("R8 high bits 128", 2'd0, 2'd2, 8'hFC, 1'b1, 1'b0, 1'b0, 16'h7000);
        run_op("R8 high bits 256", 2'd1, 2'd2, 8'hF5, 1'b1, 1'b1, 1'b0, 16'h7100);
    endtask

    task automatic t_hold();
        logic [VW-1:0] keep;
        // R9: with no strobe the result holds and valid is low.
        run_op("R9 capture", 2'd2, 2'd2, 8'h3C, 1'b1, 1'b0, 1'b0, 16'h8000);
        keep = result;
        @(negedge clk);
        src_a = pat(16'h9999); src_b = pat(16'hAAAA); old_dst = pat(16'hBBBB);
        mode_sel = 2'd1;
        @(negedge clk);
        check_vec("R9 hold no strobe", keep, 1'b0);
    endtask

    task automatic t_reset_mid();
        // R10: reset during operation clears the register.
        run_op("R10 pre-reset", 2'd2, 2'd1, 8'h00, 1'b0, 1'b0, 1'b0, 16'hC000);
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b1;
        @(negedge clk);
        check_vec("R10 reset mid-run", '0, 1'b0);
        in_valid = 1'b0;
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_lengths();
        t_legacy();
        t_bcast();
        t_mask();
        t_high_mask();
        t_hold();
        t_reset_mid();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end
endmodule